// File: doc/BRIEF.md
# Largest-Error Output Switch Selector

This block picks the output thyristor pair for a three-phase current-pulse converter once per decision. Each decision takes three signed reference line voltages and three signed measured line voltages, one of each for the line pairs UV, VW and WU. For each pair the block forms the error as reference minus measurement. It then corrects only the pair whose error has the greatest magnitude. The sign of that error decides whether the pair's capacitor is charged or discharged, and so which two of the six output switches fire.

A control loop pulses `start_i` for one cycle with the six voltages valid. On the next clock edge the block registers a six-bit gate select and the index of the chosen pair, and raises `done_o` for one cycle. Between decisions the gate select and the index hold their last values. Gate bit k drives output switch number k+1, so bit 0 is switch 1 and bit 5 is switch 6. The odd-numbered switches (bits 0, 2, 4) form the upper row and the even-numbered switches (bits 1, 3, 5) form the lower row.

Top module: `lerr_out_sel`

## Requirements
- R1: Each error is reference minus measurement, computed at full precision. With 16-bit inputs, errors up to +65535 and down to -65535 are compared without wrapping.
- R2: A decision selects the pair whose error has the largest absolute value.
- R3: When the largest magnitudes are equal, UV wins over VW and VW wins over WU. `pair_o` encodes UV as 0, VW as 1 and WU as 2, and never shows 3.
- R4: For a non-negative error, `gate_o` is 6'b000110 for UV (switches 2 and 3), 6'b011000 for VW (switches 4 and 5) and 6'b100001 for WU (switches 6 and 1).
- R5: For a negative error, `gate_o` is 6'b001001 for UV (switches 1 and 4), 6'b100100 for VW (switches 3 and 6) and 6'b010010 for WU (switches 5 and 2).
- R6: An error of exactly zero is treated as positive.
- R7: Inputs are sampled on the edge where `start_i` is high. `gate_o`, `pair_o` and a one-cycle `done_o` appear after that same edge. Without `start_i`, `done_o` stays low and `gate_o` and `pair_o` keep their values whatever the inputs do.
- R8: While `rst_ni` is low, `gate_o` and `pair_o` are zero and `done_o` is low. This takes effect at once, without waiting for a clock edge.
- R9: Whenever `gate_o` is non-zero it has exactly two bits set: one odd-numbered switch and one even-numbered switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request for a decision |
| ref_uv_i | input | 16 | Reference UV line voltage, two's complement |
| ref_vw_i | input | 16 | Reference VW line voltage, two's complement |
| ref_wu_i | input | 16 | Reference WU line voltage, two's complement |
| meas_uv_i | input | 16 | Measured UV line voltage, two's complement |
| meas_vw_i | input | 16 | Measured VW line voltage, two's complement |
| meas_wu_i | input | 16 | Measured WU line voltage, two's complement |
| gate_o | output | 6 | Output switch select, bit k is switch k+1 |
| pair_o | output | 2 | Corrected pair index (0 UV, 1 VW, 2 WU) |
| done_o | output | 1 | One-cycle strobe for a new decision |

## Verification
A decision's gate select, pair index and strobe are all due after exactly one clock edge: the edge that samples `start_i`. The bench drives inputs on the falling edge, raises `start_i` for one cycle, and reads all three results at the next falling edge. It then reads again one cycle later, expecting the strobe low and the outputs held while the inputs change. The effect of reset is due with no clock edge at all, so the bench reads the outputs a short delay after it pulls `rst_ni` low.

// File: rtl/lerr_pkg.sv
package lerr_pkg;
  localparam int unsigned N_PAIRS = 3;
  localparam int unsigned N_SW    = 6;

  typedef enum logic [1:0] {
    PAIR_UV = 2'd0,
    PAIR_VW = 2'd1,
    PAIR_WU = 2'd2
  } pair_e;
endpackage

// File: rtl/lerr_err_calc.sv
module lerr_err_calc #(
  parameter int unsigned VW = 16
) (
  input  logic signed [VW-1:0] ref_i,
  input  logic signed [VW-1:0] meas_i,
  output logic        [VW-1:0] mag_o,
  output logic                 neg_o
);
  localparam logic signed [VW:0] MOST_NEG = {1'b1, {VW{1'b0}}};

  logic signed [VW:0] err;
  logic signed [VW:0] err_inv;

  assign err     = {ref_i[VW-1], ref_i} - {meas_i[VW-1], meas_i};
  assign err_inv = -err;
  assign neg_o   = err[VW];

  // Magnitude is VW bits wide; the most negative error saturates
  always_comb begin
    if (!neg_o)               mag_o = err[VW-1:0];
    else if (err == MOST_NEG) mag_o = {VW{1'b1}};
    else                      mag_o = err_inv[VW-1:0];
  end
endmodule

// File: rtl/lerr_max_pick.sv
module lerr_max_pick #(
  parameter int unsigned MW = 16,
  parameter int unsigned NP = 3,
  localparam int unsigned IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0][MW-1:0] mag_i,
  output logic [IW-1:0]         idx_o
);
  logic [MW-1:0] best;

  // Strict compare keeps the lower index on ties
  always_comb begin
    best  = mag_i[0];
    idx_o = '0;
    for (int i = 1; i < NP; i++) begin
      if (mag_i[i] > best) begin
        best  = mag_i[i];
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lerr_gate_decode.sv
module lerr_gate_decode
  import lerr_pkg::*;
(
  input  pair_e             sel_i,
  input  logic              neg_i,
  output logic [N_SW-1:0]   gate_o
);
  always_comb begin
    unique case (sel_i)
      PAIR_UV: gate_o = neg_i ? 6'b001001 : 6'b000110;
      PAIR_VW: gate_o = neg_i ? 6'b100100 : 6'b011000;
      PAIR_WU: gate_o = neg_i ? 6'b010010 : 6'b100001;
      default: gate_o = '0;
    endcase
  end
endmodule

// File: rtl/lerr_out_sel.sv
module lerr_out_sel
  import lerr_pkg::*;
#(
  parameter int unsigned VW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [VW-1:0] ref_uv_i,
  input  logic signed [VW-1:0] ref_vw_i,
  input  logic signed [VW-1:0] ref_wu_i,
  input  logic signed [VW-1:0] meas_uv_i,
  input  logic signed [VW-1:0] meas_vw_i,
  input  logic signed [VW-1:0] meas_wu_i,
  output logic [N_SW-1:0]      gate_o,
  output logic [1:0]           pair_o,
  output logic                 done_o
);
  logic [N_PAIRS-1:0][VW-1:0] ref_v, meas_v, mag;
  logic [N_PAIRS-1:0]         neg;
  logic [1:0]                 idx;
  pair_e                      sel;
  logic [N_SW-1:0]            gate_d;

  assign ref_v  = {ref_wu_i, ref_vw_i, ref_uv_i};
  assign meas_v = {meas_wu_i, meas_vw_i, meas_uv_i};

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_err
    lerr_err_calc #(.VW(VW)) u_err (
      .ref_i  (ref_v[p]),
      .meas_i (meas_v[p]),
      .mag_o  (mag[p]),
      .neg_o  (neg[p])
    );
  end

  lerr_max_pick #(.MW(VW), .NP(N_PAIRS)) u_pick (
    .mag_i (mag),
    .idx_o (idx)
  );

  assign sel = pair_e'(idx);

  lerr_gate_decode u_dec (
    .sel_i  (sel),
    .neg_i  (neg[idx]),
    .gate_o (gate_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o <= '0;
      pair_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= start_i;
      if (start_i) begin
        gate_o <= gate_d;
        pair_o <= idx;
      end
    end
  end
endmodule

// File: rtl/lerr_out_sel_chk.sv
module lerr_out_sel_chk #(
  parameter int unsigned VW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic signed [VW-1:0] ref_uv_i,
  input logic signed [VW-1:0] ref_vw_i,
  input logic signed [VW-1:0] ref_wu_i,
  input logic signed [VW-1:0] meas_uv_i,
  input logic signed [VW-1:0] meas_vw_i,
  input logic signed [VW-1:0] meas_wu_i,
  input logic [5:0]           gate_o,
  input logic [1:0]           pair_o,
  input logic                 done_o
);
  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  int cap_uv, cap_vw, cap_wu, cap_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_uv <= 0;
      cap_vw <= 0;
      cap_wu <= 0;
    end else if (start_i) begin
      cap_uv <= iabs(int'(ref_uv_i) - int'(meas_uv_i));
      cap_vw <= iabs(int'(ref_vw_i) - int'(meas_vw_i));
      cap_wu <= iabs(int'(ref_wu_i) - int'(meas_wu_i));
    end
  end

  always_comb begin
    case (pair_o)
      2'd0:    cap_sel = cap_uv;
      2'd1:    cap_sel = cap_vw;
      default: cap_sel = cap_wu;
    endcase
  end

  AST_PICK_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cap_sel >= cap_uv && cap_sel >= cap_vw && cap_sel >= cap_wu)); // R2
  AST_PAIR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_o != 2'd3); // R3
  AST_DONE_FROM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (!done_o && $stable(gate_o) && $stable(pair_o))); // R7
  AST_TWO_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones(gate_o) == 2); // R9
  AST_ROWS_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != 6'd0) |-> $countones(gate_o & 6'b010101) == 1); // R9
endmodule

bind lerr_out_sel lerr_out_sel_chk #(.VW(VW)) u_chk (.*);

// File: tb/sim_lerr_out_sel.sv
module sim_lerr_out_sel;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic signed [15:0] ref_uv_i = '0, ref_vw_i = '0, ref_wu_i = '0;
  logic signed [15:0] meas_uv_i = '0, meas_vw_i = '0, meas_wu_i = '0;
  logic [5:0] gate_o;
  logic [1:0] pair_o;
  logic       done_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit ended = 0;

  always #4 clk_i = ~clk_i;

  lerr_out_sel u0 (.*);

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  function automatic int exp_pair(int e0, int e1, int e2);
    int m0 = (e0 < 0) ? -e0 : e0;
    int m1 = (e1 < 0) ? -e1 : e1;
    int m2 = (e2 < 0) ? -e2 : e2;
    int idx = 0, best = m0;
    if (m1 > best) begin idx = 1; best = m1; end
    if (m2 > best) idx = 2;
    return idx;
  endfunction

  function automatic int exp_gate(int idx, int e);
    if (e >= 0) return (idx == 0) ? 6'b000110 : (idx == 1) ? 6'b011000 : 6'b100001;
    return (idx == 0) ? 6'b001001 : (idx == 1) ? 6'b100100 : 6'b010010;
  endfunction

  // Drive a decision on a falling edge, read after the sampling rising edge
  task automatic decide(string req, int r0, int r1, int r2, int m0, int m1, int m2);
    int e[3];
    int idx;
    ref_uv_i = 16'(r0); ref_vw_i = 16'(r1); ref_wu_i = 16'(r2);
    meas_uv_i = 16'(m0); meas_vw_i = 16'(m1); meas_wu_i = 16'(m2);
    e[0] = r0 - m0; e[1] = r1 - m1; e[2] = r2 - m2;
    idx = exp_pair(e[0], e[1], e[2]);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk({req, " pair"}, int'(pair_o), idx);
    chk({req, " gate"}, int'(gate_o), exp_gate(idx, e[idx]));
    chk("R7 done", int'(done_o), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R8 reset gate", int'(gate_o), 0);
    chk("R8 reset pair", int'(pair_o), 0);
    chk("R8 reset done", int'(done_o), 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 no start done", int'(done_o), 0);

    // R6 / R3: all zero errors -> UV positive
    decide("R6", 0, 0, 0, 0, 0, 0);
    chk("R6 zero gate", int'(gate_o), 6'b000110);
    // R4: positive errors per pair
    decide("R4", 100, 500, 3, 90, 0, 0);
    chk("R4 VW pos", int'(gate_o), 6'b011000);
    decide("R4", 1, 2, 900, 0, 0, -5);
    chk("R4 WU pos", int'(gate_o), 6'b100001);
    // R5: negative errors per pair
    decide("R5", -700, 10, 0, 0, 0, 0);
    chk("R5 UV neg", int'(gate_o), 6'b001001);
    decide("R5", 0, -700, 0, 0, 0, 0);
    chk("R5 VW neg", int'(gate_o), 6'b100100);
    decide("R5", 0, 0, 20, 0, 0, 800);
    chk("R5 WU neg", int'(gate_o), 6'b010010);
    // R3: ties
    decide("R3", 0, 50, -50, 0, 0, 0);
    chk("R3 VW over WU", int'(pair_o), 1);
    decide("R3", -50, 50, 50, 0, 0, 0);
    chk("R3 UV over all", int'(gate_o), 6'b001001);
    // R1: full-range errors, tie at 65535 with opposite signs
    decide("R1", 10, -32768, 32767, 0, 32767, -32768);
    chk("R1 VW neg extreme", int'(gate_o), 6'b100100);
    decide("R1", 0, 32767, 0, 0, -32768, 32767);
    chk("R1 VW pos extreme", int'(gate_o), 6'b011000);

    // R2/R4/R5/R7: random decisions, each followed by an idle hold check
    for (int k = 0; k < 300; k++) begin
      logic [5:0] g;
      logic [1:0] p;
      decide("R2", int'($signed(16'($urandom))), int'($signed(16'($urandom))),
             int'($signed(16'($urandom))), int'($signed(16'($urandom))),
             int'($signed(16'($urandom))), int'($signed(16'($urandom))));
      g = gate_o; p = pair_o;
      ref_uv_i = 16'($urandom); meas_wu_i = 16'($urandom); ref_vw_i = 16'($urandom);
      @(negedge clk_i);
      chk("R7 hold gate", int'(gate_o), int'(g));
      chk("R7 hold pair", int'(pair_o), int'(p));
      chk("R7 idle done", int'(done_o), 0);
    end

    // R8: asynchronous reset mid-run
    decide("R5", 0, 0, 0, 0, 0, 1);
    rst_ni = 1'b0;
    #1;
    chk("R8 async gate", int'(gate_o), 0);
    chk("R8 async pair", int'(pair_o), 0);
    chk("R8 async done", int'(done_o), 0);
    @(negedge clk_i);
    chk("R8 held gate", int'(gate_o), 0);
    finish_run();
  end
endmodule